// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Port

This block receives configuration frames on a three-wire serial link (data, shift clock, latch strobe) and holds the decoded settings that the rest of the receiver chip uses: the synthesizer main, swallow and reference divide values, the reference clock output enable, the IF filter shape select, the test-path enable, and the test injection and observation location codes. Each frame has 18 bits. Sixteen payload bits come first, least significant first. A two-bit register address follows them. A rising edge on the latch pin commits the payload into the addressed register.

All three serial pins and the enable pin are asynchronous to the system clock, so each passes through a two-flop synchronizer, and edges are found on the synchronized copies. When enable goes high, the block reloads its settings from one of three default sets. The levels on the serial pins at that moment choose the set, so the part runs with no programming. While enable is low, the port ignores serial traffic. A latch that arrives before a full frame has been shifted in is dropped and sets a sticky error flag.

Top module: `cfg_serial_port`

## Requirements
- R1: A frame is shifted on rising edges of the serial clock, with data sampled at each edge, in the order payload bit 0 up to payload bit 15, then address bit 0, then address bit 1.
- R2: A latch rising edge writes the payload only into the register named by the two address bits, and the other three registers keep their values.
- R3: Address 0 sets the 11-bit main divide value from payload bits 10..0. Address 1 sets the 5-bit swallow value from bits 15..11 and the 9-bit reference divide value from bits 8..0.
- R4: Address 2 sets the 3-bit test injection location from bits 15..13, the clock output enable from bit 6 and the test enable from bit 3. Address 3 sets the 3-bit test observation location from bits 15..13 and the filter select from bit 7, where 0 gives low-pass and 1 gives band-pass.
- R5: Payload bits outside the fields of R3 and R4 have no effect on any output.
- R6: On an enable rising edge the strap code {data, clk, latch} loads a default set. Code 000 loads main 6, swallow 0, reference 3, band-pass, test enable 1, both locations 6, clock output off. Code 100 loads main 7, swallow 3, reference 4, low-pass, test off, locations 0, clock output off. Code 110 loads main 22, swallow 17, reference 9, low-pass, test off, locations 0, clock output off. The same edge clears the error flag.
- R7: Any other strap code loads the code-000 set.
- R8: While enable is low, serial clock and latch activity change no output.
- R9: A latch rising edge after fewer than 18 serial clock rising edges since the previous latch, or since enable rose, writes nothing and sets the error flag. The flag stays set until reset or the next enable rising edge.
- R10: When more than 18 clock edges come before a latch, the last 18 bits shifted in form the frame.
- R11: After reset every output holds the code-000 default set and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Active/power-save select; rising edge reloads defaults |
| ser_data_i | input | 1 | Serial data, also strap bit 2 |
| ser_clk_i | input | 1 | Serial shift clock, also strap bit 1 |
| ser_latch_i | input | 1 | Latch strobe, also strap bit 0 |
| main_div_o | output | 11 | Synthesizer main divide value |
| swallow_o | output | 5 | Synthesizer swallow value |
| ref_div_o | output | 9 | Reference divide value |
| clk_out_en_o | output | 1 | Reference clock output enable |
| test_en_o | output | 1 | Test path enable |
| test_in_loc_o | output | 3 | Test injection location code |
| test_out_loc_o | output | 3 | Test observation location code |
| filt_bpf_o | output | 1 | Filter select, 1 = band-pass |
| frame_err_o | output | 1 | Sticky short-frame flag |

## Verification
Random frames with random addresses and payloads check the field mapping and confirm that each write reaches only its addressed register. Directed payloads of all ones, and payloads that set only bits outside the fields, show whether a field is misplaced or whether a stray bit leaks through. Each strap code, plus one code outside the listed ones, gets its own enable cycle so that wrong default routing shows up. Short frames, overlong frames and traffic while enable is low exercise the bit counter: they show whether it discards short frames, keeps only the last 18 bits, and is held during power-save.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DATA_BITS  = 16;
  localparam int ADDR_BITS  = 2;
  localparam int FRAME_BITS = DATA_BITS + ADDR_BITS;
  localparam int MC_W       = 11;
  localparam int SC_W       = 5;
  localparam int RC_W       = 9;
  localparam int LOC_W      = 3;
  localparam int SC_LSB     = DATA_BITS - SC_W;
  localparam int LOC_LSB    = DATA_BITS - LOC_W;
  localparam int CLKOUT_BIT = 6;
  localparam int TEST_BIT   = 3;
  localparam int FILT_BIT   = 7;

  typedef struct packed {
    logic [MC_W-1:0]  main_div;
    logic [SC_W-1:0]  swallow;
    logic [RC_W-1:0]  ref_div;
    logic             clk_out_en;
    logic             test_en;
    logic [LOC_W-1:0] tin_loc;
    logic [LOC_W-1:0] tout_loc;
    logic             filt_bpf;
  } cfg_t;

  localparam cfg_t DEF_SET_A = '{main_div: 11'd6, swallow: 5'd0, ref_div: 9'd3,
                                 clk_out_en: 1'b0, test_en: 1'b1, tin_loc: 3'd6,
                                 tout_loc: 3'd6, filt_bpf: 1'b1};
  localparam cfg_t DEF_SET_B = '{main_div: 11'd7, swallow: 5'd3, ref_div: 9'd4,
                                 clk_out_en: 1'b0, test_en: 1'b0, tin_loc: 3'd0,
                                 tout_loc: 3'd0, filt_bpf: 1'b0};
  localparam cfg_t DEF_SET_C = '{main_div: 11'd22, swallow: 5'd17, ref_div: 9'd9,
                                 clk_out_en: 1'b0, test_en: 1'b0, tin_loc: 3'd0,
                                 tout_loc: 3'd0, filt_bpf: 1'b0};

  // Merge one payload word into the current settings; only defined fields move.
  function automatic cfg_t apply_word(cfg_t cur, logic [ADDR_BITS-1:0] addr,
                                      logic [DATA_BITS-1:0] w);
    cfg_t n;
    n = cur;
    case (addr)
      2'd0: n.main_div = w[MC_W-1:0];
      2'd1: begin
        n.swallow = w[SC_LSB +: SC_W];
        n.ref_div = w[RC_W-1:0];
      end
      2'd2: begin
        n.tin_loc    = w[LOC_LSB +: LOC_W];
        n.clk_out_en = w[CLKOUT_BIT];
        n.test_en    = w[TEST_BIT];
      end
      default: begin
        n.tout_loc = w[LOC_LSB +: LOC_W];
        n.filt_bpf = w[FILT_BIT];
      end
    endcase
    return n;
  endfunction

  // Strap code is {data, clk, latch}; unknown codes use the first set.
  function automatic cfg_t pick_default(logic [2:0] strap, cfg_t a, cfg_t b, cfg_t c);
    case (strap)
      3'b100:  return b;
      3'b110:  return c;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 sclk,
  input  logic                 sdat,
  input  logic                 slat,
  output logic                 sclk_rise,
  output logic                 slat_rise,
  output logic                 frame_ok,
  output logic                 frame_bad,
  output logic [ADDR_BITS-1:0] frame_addr,
  output logic [DATA_BITS-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic                  sclk_q, slat_q;
  logic [FRAME_BITS-1:0] sr;
  logic [CNT_W-1:0]      cnt;
  logic                  full;

  assign sclk_rise = run & sclk & ~sclk_q;
  assign slat_rise = run & slat & ~slat_q;
  assign full      = (cnt == CNT_W'(FRAME_BITS));
  assign frame_ok  = slat_rise & full;
  assign frame_bad = slat_rise & ~full;
  assign frame_addr = sr[FRAME_BITS-1 -: ADDR_BITS];
  assign frame_word = sr[DATA_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      slat_q <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk;
      slat_q <= slat;
      if (!run) begin
        sr  <= '0;
        cnt <= '0;
      end else if (slat_rise) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sr <= {sdat, sr[FRAME_BITS-1:1]};
        if (!full) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_port_pkg::*;
#(
  parameter cfg_t RESET_SET = DEF_SET_A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_pulse,
  input  cfg_t                 dflt_cfg,
  input  logic                 frame_ok,
  input  logic                 frame_bad,
  input  logic [ADDR_BITS-1:0] frame_addr,
  input  logic [DATA_BITS-1:0] frame_word,
  output cfg_t                 cfg_q,
  output logic                 frame_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= RESET_SET;
      frame_err <= 1'b0;
    end else if (init_pulse) begin
      cfg_q     <= dflt_cfg;
      frame_err <= 1'b0;
    end else begin
      if (frame_ok)  cfg_q     <= apply_word(cfg_q, frame_addr, frame_word);
      if (frame_bad) frame_err <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter cfg_t SET_A = DEF_SET_A,
  parameter cfg_t SET_B = DEF_SET_B,
  parameter cfg_t SET_C = DEF_SET_C,
  parameter int   SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             ser_data_i,
  input  logic             ser_clk_i,
  input  logic             ser_latch_i,
  output logic [MC_W-1:0]  main_div_o,
  output logic [SC_W-1:0]  swallow_o,
  output logic [RC_W-1:0]  ref_div_o,
  output logic             clk_out_en_o,
  output logic             test_en_o,
  output logic [LOC_W-1:0] test_in_loc_o,
  output logic [LOC_W-1:0] test_out_loc_o,
  output logic             filt_bpf_o,
  output logic             frame_err_o
);
  logic [3:0] pins_s;
  logic en_s, dat_s, sclk_s, lat_s, en_q;
  logic init_pulse, run;
  logic [2:0] strap;
  cfg_t dflt_pick, cfg_q;
  logic sclk_rise, slat_rise, frame_ok, frame_bad, frame_err;
  logic [ADDR_BITS-1:0] frame_addr;
  logic [DATA_BITS-1:0] frame_word;

  cfg_sync #(.W(4), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({enable_i, ser_data_i, ser_clk_i, ser_latch_i}),
    .q(pins_s));

  assign {en_s, dat_s, sclk_s, lat_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_s;
  end

  assign init_pulse = en_s & ~en_q;
  assign run        = en_s & en_q;
  assign strap      = {dat_s, sclk_s, lat_s};
  assign dflt_pick  = pick_default(strap, SET_A, SET_B, SET_C);

  cfg_frame_rx rx_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk_s), .sdat(dat_s), .slat(lat_s),
    .sclk_rise(sclk_rise), .slat_rise(slat_rise),
    .frame_ok(frame_ok), .frame_bad(frame_bad),
    .frame_addr(frame_addr), .frame_word(frame_word));

  cfg_bank #(.RESET_SET(SET_A)) bank_i (
    .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse), .dflt_cfg(dflt_pick),
    .frame_ok(frame_ok), .frame_bad(frame_bad),
    .frame_addr(frame_addr), .frame_word(frame_word),
    .cfg_q(cfg_q), .frame_err(frame_err));

  assign main_div_o     = cfg_q.main_div;
  assign swallow_o      = cfg_q.swallow;
  assign ref_div_o      = cfg_q.ref_div;
  assign clk_out_en_o   = cfg_q.clk_out_en;
  assign test_en_o      = cfg_q.test_en;
  assign test_in_loc_o  = cfg_q.tin_loc;
  assign test_out_loc_o = cfg_q.tout_loc;
  assign filt_bpf_o     = cfg_q.filt_bpf;
  assign frame_err_o    = frame_err;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfg_port_pkg::*;
#(
  parameter cfg_t SET_A = DEF_SET_A
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic                 init_pulse,
  input logic [2:0]           strap,
  input logic                 frame_ok,
  input logic                 frame_bad,
  input logic [ADDR_BITS-1:0] frame_addr,
  input cfg_t                 cfg_q,
  input logic                 frame_err
);
  AST_INIT_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> !frame_err); // R6
  AST_UNLISTED_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (init_pulse && strap != 3'b100 && strap != 3'b110) |=> (cfg_q == SET_A)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !init_pulse) |=> $stable(cfg_q)); // R8
  AST_IDLE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(frame_ok || frame_bad)); // R8
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> $stable(cfg_q)); // R9
  AST_BAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> frame_err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !init_pulse) |=> frame_err); // R9
  AST_ADDR0_ONLY_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && frame_addr == 2'd0) |=>
      ($stable(cfg_q.swallow) && $stable(cfg_q.ref_div) && $stable(cfg_q.tin_loc) &&
       $stable(cfg_q.tout_loc) && $stable(cfg_q.filt_bpf) && $stable(cfg_q.test_en))); // R2
endmodule

bind cfg_serial_port cfg_serial_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .init_pulse(init_pulse), .strap(strap),
  .frame_ok(frame_ok), .frame_bad(frame_bad), .frame_addr(frame_addr),
  .cfg_q(cfg_q), .frame_err(frame_err));

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, sdat = 1'b0, sclk = 1'b0, slat = 1'b0;
  logic [10:0] main_div;
  logic [4:0]  swallow;
  logic [8:0]  ref_div;
  logic        clk_out_en, test_en, filt_bpf, frame_err;
  logic [2:0]  tin_loc, tout_loc;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_mc, m_sc, m_rc, m_ck, m_te, m_ti, m_to, m_fl, m_err;

  always #10 clk = ~clk;

  cfg_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .ser_data_i(sdat),
    .ser_clk_i(sclk), .ser_latch_i(slat), .main_div_o(main_div),
    .swallow_o(swallow), .ref_div_o(ref_div), .clk_out_en_o(clk_out_en),
    .test_en_o(test_en), .test_in_loc_o(tin_loc), .test_out_loc_o(tout_loc),
    .filt_bpf_o(filt_bpf), .frame_err_o(frame_err));

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " main"}, main_div, m_mc);
    chk({req, " swallow"}, swallow, m_sc);
    chk({req, " ref"}, ref_div, m_rc);
    chk({req, " clkout"}, clk_out_en, m_ck);
    chk({req, " test_en"}, test_en, m_te);
    chk({req, " tin"}, tin_loc, m_ti);
    chk({req, " tout"}, tout_loc, m_to);
    chk({req, " filter"}, filt_bpf, m_fl);
    chk({req, " err"}, frame_err, m_err);
  endtask

  // Default sets as listed in R6; unlisted codes fall to the first (R7).
  function automatic void model_default(bit [2:0] strap);
    m_ck = 0; m_err = 0;
    if (strap == 3'b100) begin
      m_mc = 7; m_sc = 3; m_rc = 4; m_fl = 0; m_te = 0; m_ti = 0; m_to = 0;
    end else if (strap == 3'b110) begin
      m_mc = 22; m_sc = 17; m_rc = 9; m_fl = 0; m_te = 0; m_ti = 0; m_to = 0;
    end else begin
      m_mc = 6; m_sc = 0; m_rc = 3; m_fl = 1; m_te = 1; m_ti = 6; m_to = 6;
    end
  endfunction

  // Field layout restated from R3/R4 with arithmetic on the word.
  function automatic void model_write(int a, int word);
    case (a)
      0: m_mc = word % 2048;
      1: begin m_sc = word / 2048; m_rc = word % 512; end
      2: begin m_ti = word / 8192; m_ck = (word / 64) % 2; m_te = (word / 8) % 2; end
      default: begin m_to = word / 8192; m_fl = (word / 128) % 2; end
    endcase
  endfunction

  task automatic put_bit(bit b);
    sdat = b; w(3); sclk = 1'b1; w(3); sclk = 1'b0; w(2);
  endtask

  // extra: junk bits before the frame; nbits: frame bits actually sent.
  task automatic send(int a, int word, int extra, int nbits);
    logic [17:0] f;
    f = {a[1:0], word[15:0]};
    for (int i = 0; i < extra; i++) put_bit(1'($urandom));
    for (int i = 0; i < nbits; i++) put_bit(f[i]);
    sdat = 1'b0; w(2);
    slat = 1'b1; w(4); slat = 1'b0; w(8);
  endtask

  task automatic do_enable(bit [2:0] strap);
    enable = 1'b0; w(6);
    {sdat, sclk, slat} = strap; w(3);
    enable = 1'b1; w(8);
    {sdat, sclk, slat} = 3'b000; w(6);
    model_default(strap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    w(5); rst_n = 1'b1; w(5);
    model_default(3'b000);
    check_all("R11");

    do_enable(3'b100); check_all("R6 set100");
    do_enable(3'b110); check_all("R6 set110");
    do_enable(3'b000); check_all("R6 set000");
    do_enable(3'b100);
    do_enable(3'b011); check_all("R7 strap011");
    do_enable(3'b101); check_all("R7 strap101");

    // R1/R3: distinct bit patterns through the shift order
    send(1, 16'hA1C5, 0, 18); model_write(1, 16'hA1C5); check_all("R1 R3 addr1");
    send(0, 16'h0555, 0, 18); model_write(0, 16'h0555); check_all("R1 R3 addr0");
    // R4
    send(2, 16'hE048, 0, 18); model_write(2, 16'hE048); check_all("R4 addr2");
    send(3, 16'hA080, 0, 18); model_write(3, 16'hA080); check_all("R4 addr3");
    // R5: only non-field bits set
    send(2, 16'h1FB7, 0, 18); model_write(2, 16'h1FB7); check_all("R5 addr2 stray");
    send(3, 16'h1F7F, 0, 18); model_write(3, 16'h1F7F); check_all("R5 addr3 stray");
    send(0, 16'hF800, 0, 18); model_write(0, 16'hF800); check_all("R5 addr0 stray");
    send(0, 16'hFFFF, 0, 18); model_write(0, 16'hFFFF); check_all("R5 addr0 ones");

    // R8: traffic with enable low
    enable = 1'b0; w(6);
    send(0, 16'h0123, 0, 18); check_all("R8 full frame idle");
    send(1, 16'h0042, 0, 5);  check_all("R8 short frame idle");
    do_enable(3'b110); check_all("R6 after idle");

    // R9: short frame, then a good one, then re-init clears
    send(0, 16'h0321, 0, 10); m_err = 1; check_all("R9 short");
    send(0, 16'h0111, 0, 18); model_write(0, 16'h0111); check_all("R9 sticky");
    do_enable(3'b100); check_all("R9 cleared by enable");

    // R10: extra leading bits
    send(1, 16'h3A07, 5, 18); model_write(1, 16'h3A07); check_all("R10 long");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int a, word, nb;
      a = int'($urandom % 4);
      word = int'($urandom % 65536);
      if ($urandom % 8 == 0) begin
        nb = 1 + int'($urandom % 17);
        send(a, word, 0, nb); m_err = 1;
        check_all("R9 random short");
      end else begin
        send(a, word, int'($urandom % 3), 18); model_write(a, word);
        check_all("R2 random");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule